// File: doc/BRIEF.md
# Bit-Clock Per-Frame Consistency Checker

This block watches a PCM bit clock against its frame sync once the block comes out of reset. It runs in the bit-clock domain. It counts bit-clock cycles between consecutive rising edges of frame sync and reports each result. The first eight complete frames give the clock time to settle, so they are measured but not judged.

Over the next eight complete frames the block judges every count on two tests. Each count must equal the first count of that window, and it must be one of the allowed rates: 256, 512, 1024, 1536 or 2048 cycles per frame. If either test fails, a sticky error flag is set. An interrupt line follows that flag while the interrupt enable is set, and the enable is set out of reset. After the sixteenth frame the block stops judging for good.

The host clears the flag with a one-cycle clear pulse. Recovering the clock and acting on the error are left to the surrounding logic.

Top module: `pclk_frame_checker`

## Requirements
- R1: While reset is high and on the first cycle after it, `err_flag`, `irq` and `meas_count` are all 0. The interrupt enable resets to 1.
- R2: Two cycles after each frame-sync rising edge that closes a frame, `meas_count` holds the number of `clk` rising edges between that edge and the previous frame-sync rising edge.
- R3: The counts of complete frames 1 to 8 never set `err_flag`, whatever their values.
- R4: `err_flag` is set if any count among complete frames 9 to 16 differs from the count of frame 9.
- R5: `err_flag` is set if any count among frames 9 to 16 is not 256, 512, 1024, 1536 or 2048, even when all eight counts are equal.
- R6: If frames 9 to 16 all have the same allowed count, `err_flag` stays 0.
- R7: After frame 16 completes, no later frame sets `err_flag`.
- R8: The per-frame count saturates at 2^CNT_W-1, which is 4095 by default. A frame longer than that reports 4095, and in frames 9 to 16 it counts as a disallowed rate.
- R9: `err_flag` stays set until `err_clr` is high at a clock edge. `err_flag` reads 0 after that edge, and a set in the same cycle takes priority over the clear.
- R10: `irq` equals `err_flag` ANDed with the interrupt enable, both taken one cycle earlier. A cycle with `cfg_we` high loads `cfg_irq_en` into the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock; every register runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync; a rising edge marks a frame boundary |
| cfg_we | input | 1 | Write strobe for the interrupt enable |
| cfg_irq_en | input | 1 | New interrupt enable value, loaded when `cfg_we` is high |
| err_clr | input | 1 | Clear pulse for the sticky error flag |
| err_flag | output | 1 | Sticky rate or consistency error |
| irq | output | 1 | Interrupt: the error flag gated by the enable |
| meas_count | output | CNT_W | Count of the most recently completed frame |

## Verification
The bench builds the checker with its default parameters: a 12-bit counter, eight skipped frames and eight checked frames. The 12-bit width lets a single over-long frame of 5000 cycles reach the 4095 saturation value, and the whole power-up sequence still stays within a few thousand cycles when the frame lengths are short. The same defaults cover every allowed rate, including 2048 at the top of the table. Eight skipped frames also leave room to give the judged window frame lengths in the settling frames that would otherwise be errors.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int unsigned N_RATES = 5;

  function automatic int unsigned rate_value(input int unsigned idx);
    case (idx)
      0: rate_value = 256;
      1: rate_value = 512;
      2: rate_value = 1024;
      3: rate_value = 1536;
      default: rate_value = 2048;
    endcase
  endfunction
endpackage

// File: rtl/pfc_edge.sv
module pfc_edge (
  input  logic clk,
  input  logic rst,
  input  logic fsync,
  output logic rise
);
  logic fs_q1, fs_q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q1 <= 1'b0;
      fs_q2 <= 1'b0;
    end else begin
      fs_q1 <= fsync;
      fs_q2 <= fs_q1;
    end
  end

  assign rise = fs_q1 & ~fs_q2;
endmodule

// File: rtl/pfc_frame_counter.sv
module pfc_frame_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (rise)           cnt <= CNT_W'(1);
    else if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
  end

  // R8: holds at the ceiling until a boundary restarts it
  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !rise) |=> (cnt == CNT_MAX));
  // R2: every boundary restarts the count at one
  a_r2_restart: assert property (@(posedge clk) disable iff (rst)
    rise |=> (cnt == CNT_W'(1)));
endmodule

// File: rtl/pfc_rate_match.sv
module pfc_rate_match
  import pfc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] cnt,
  output logic             allowed
);
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;
  logic [N_RATES-1:0] hit;

  for (genvar i = 0; i < N_RATES; i++) begin : g_rate
    if (rate_value(i) <= CNT_MAX) begin : g_fit
      assign hit[i] = (32'(cnt) == rate_value(i));
    end else begin : g_nofit
      assign hit[i] = 1'b0;
    end
  end

  assign allowed = |hit;
endmodule

// File: rtl/pfc_window_seq.sv
module pfc_window_seq #(
  parameter int CNT_W        = 12,
  parameter int SKIP_FRAMES  = 8,
  parameter int CHECK_FRAMES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic [CNT_W-1:0] cnt,
  input  logic             allowed,
  output logic             frame_end,
  output logic             err_set,
  output logic             done
);
  localparam int TOTAL = SKIP_FRAMES + CHECK_FRAMES;
  localparam int FN_W  = $clog2(TOTAL + 1);
  localparam logic [FN_W-1:0] FN_SKIP  = FN_W'(SKIP_FRAMES);
  localparam logic [FN_W-1:0] FN_TOTAL = FN_W'(TOTAL);

  logic             started;
  logic [FN_W-1:0]  fnum;
  logic [CNT_W-1:0] ref_cnt;
  logic             in_window, first_checked, mismatch;

  assign frame_end     = rise & started;
  assign done          = (fnum == FN_TOTAL);
  assign in_window     = (fnum >= FN_SKIP) && !done;
  assign first_checked = (fnum == FN_SKIP);
  assign mismatch      = !first_checked && (cnt != ref_cnt);
  assign err_set       = frame_end && in_window && (!allowed || mismatch);

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      fnum    <= '0;
      ref_cnt <= '0;
    end else if (rise) begin
      started <= 1'b1;
      if (started && !done) begin
        fnum <= fnum + FN_W'(1);
        if (first_checked) ref_cnt <= cnt;
      end
    end
  end

  // R7: once finished the sequencer never leaves the done state
  a_r7_done_hold: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  // R3: frame number only moves forward by one per boundary
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (!frame_end && !done) |=> $stable(fnum));
endmodule

// File: rtl/pclk_frame_checker.sv
module pclk_frame_checker #(
  parameter int CNT_W        = 12,
  parameter int SKIP_FRAMES  = 8,
  parameter int CHECK_FRAMES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fsync,
  input  logic             cfg_we,
  input  logic             cfg_irq_en,
  input  logic             err_clr,
  output logic             err_flag,
  output logic             irq,
  output logic [CNT_W-1:0] meas_count
);
  logic             rise, allowed, frame_end, err_set, done;
  logic [CNT_W-1:0] cnt;
  logic             irq_en_q;

  pfc_edge u_edge (
    .clk(clk), .rst(rst), .fsync(fsync), .rise(rise)
  );

  pfc_frame_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .rise(rise), .cnt(cnt)
  );

  pfc_rate_match #(.CNT_W(CNT_W)) u_match (
    .cnt(cnt), .allowed(allowed)
  );

  pfc_window_seq #(
    .CNT_W(CNT_W), .SKIP_FRAMES(SKIP_FRAMES), .CHECK_FRAMES(CHECK_FRAMES)
  ) u_seq (
    .clk(clk), .rst(rst), .rise(rise), .cnt(cnt), .allowed(allowed),
    .frame_end(frame_end), .err_set(err_set), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag   <= 1'b0;
      irq        <= 1'b0;
      irq_en_q   <= 1'b1;
      meas_count <= '0;
    end else begin
      err_flag <= err_set | (err_flag & ~err_clr);
      irq      <= err_flag & irq_en_q;
      if (cfg_we)    irq_en_q   <= cfg_irq_en;
      if (frame_end) meas_count <= cnt;
    end
  end

  // R9: flag holds without a clear
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag);
  // R10: disabled interrupt stays low
  a_r10_masked: assert property (@(posedge clk) disable iff (rst)
    !irq_en_q |=> !irq);
  // R7: nothing raises the flag after the window closes
  a_r7_quiet_done: assert property (@(posedge clk) disable iff (rst)
    (done && !err_flag) |=> !err_flag);
  // R2: report changes only at frame boundaries
  a_r2_meas_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(meas_count));
endmodule

// File: tb/pclk_frame_checker_test.sv
module pclk_frame_checker_test;
  localparam int CNT_W = 12;
  localparam int MAXC  = 4095;

  logic clk = 0, rst = 1, fsync = 0, cfg_we = 0, cfg_irq_en = 0, err_clr = 0;
  logic err_flag, irq;
  logic [CNT_W-1:0] meas_count;

  int n_cmp = 0, n_bad = 0;
  int lens[16];
  bit dog = 0;

  pclk_frame_checker #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .fsync(fsync), .cfg_we(cfg_we),
    .cfg_irq_en(cfg_irq_en), .err_clr(err_clr),
    .err_flag(err_flag), .irq(irq), .meas_count(meas_count)
  );

  always #10 clk = ~clk;

  function automatic bit is_allowed(int v);
    return v == 256 || v == 512 || v == 1024 || v == 1536 || v == 2048;
  endfunction

  function automatic int sat(int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  function automatic bit exp_err();
    bit e = 0;
    for (int i = 8; i < 16; i++)
      if (!is_allowed(sat(lens[i])) || sat(lens[i]) != sat(lens[8])) e = 1;
    return e;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; fsync = 0; err_clr = 0; cfg_we = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  // one frame of n cycles; checks the report of the previous frame (R2)
  task automatic send_frame(int n, int prev);
    @(negedge clk); fsync = 1;
    @(negedge clk); fsync = 0;
    @(negedge clk);
    if (prev > 0) check("R2/R8 meas_count", int'(meas_count), sat(prev));
    repeat (n - 3) @(negedge clk);
  endtask

  // power-up sequence of 16 frames plus the closing edge
  task automatic run_seq(string req);
    int prev = 0;
    for (int i = 0; i < 16; i++) begin
      send_frame(lens[i], prev);
      if (i == 7) check("R3 no error in skipped frames", int'(err_flag), 0);
      prev = lens[i];
    end
    send_frame(4, prev);
    repeat (3) @(negedge clk);
    check(req, int'(err_flag), int'(exp_err()));
  endtask

  task automatic fill(int skip_len, int chk_len);
    for (int i = 0; i < 8; i++) lens[i] = skip_len;
    for (int i = 8; i < 16; i++) lens[i] = chk_len;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    dog = 1;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_1234);
    fork
      begin : main
        do_reset();
        // R1 reset state
        @(negedge clk);
        check("R1 err_flag", int'(err_flag), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 meas_count", int'(meas_count), 0);

        // R6 consistent allowed; R3 junk in skip frames
        fill(256, 256);
        for (int i = 0; i < 8; i++) lens[i] = 40 + 37 * i;
        run_seq("R6 steady 256");
        check("R6 irq", int'(irq), 0);

        // R7 after done, bad frames ignored
        send_frame(100, 0); send_frame(333, 100); send_frame(4, 333);
        repeat (3) @(negedge clk);
        check("R7 no error after done", int'(err_flag), 0);
        check("R2 meas after done", int'(meas_count), 333);

        // R4 inconsistency; R10 irq on by default
        do_reset();
        fill(50, 512); lens[13] = 1024;
        run_seq("R4 mismatch");
        check("R10 irq default enabled", int'(irq), 1);

        // R9 sticky then cleared
        repeat (20) @(negedge clk);
        check("R9 sticky", int'(err_flag), 1);
        err_clr = 1; @(negedge clk); err_clr = 0;
        check("R9 cleared", int'(err_flag), 0);
        @(negedge clk);
        check("R10 irq follows clear", int'(irq), 0);

        // R5 consistent but disallowed; R10 masked
        do_reset();
        @(negedge clk); cfg_we = 1; cfg_irq_en = 0; @(negedge clk); cfg_we = 0;
        fill(30, 300);
        run_seq("R5 disallowed 300");
        check("R10 irq masked", int'(irq), 0);
        @(negedge clk); cfg_we = 1; cfg_irq_en = 1; @(negedge clk); cfg_we = 0;
        @(negedge clk);
        check("R10 irq after enable", int'(irq), 1);

        // R6 top rate 2048
        do_reset();
        fill(20, 2048);
        run_seq("R6 steady 2048");

        // R8 missing sync inside window
        do_reset();
        fill(20, 1536); lens[10] = 5000;
        run_seq("R8 saturated frame");

        // R3 missing sync only in skip frames
        do_reset();
        fill(20, 1024); lens[3] = 5000;
        run_seq("R3 long skip frame");

        // random runs
        for (int r = 0; r < 6; r++) begin
          int base;
          do_reset();
          case ($urandom_range(0, 2))
            0: base = 256;
            1: base = 512;
            default: base = $urandom_range(200, 600);
          endcase
          for (int i = 0; i < 8; i++) lens[i] = $urandom_range(10, 300);
          for (int i = 8; i < 16; i++) lens[i] = base;
          if ($urandom_range(0, 1)) lens[$urandom_range(8, 15)] = base + $urandom_range(1, 3);
          run_seq("R4/R5/R6 random");
        end
        disable wd;
      end
      begin : wd
        wait (dog);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        disable main;
      end
    join
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule